// File: doc/BRIEF.md
# Latched Thermal Trip Controller

This block guards a die against a catastrophic cooling failure. It compares a digital junction-temperature code with a programmable trip level. When the temperature reaches that level, it pulls an active-low, open-drain trip pin low and asserts a request that stops all internal clocks. Once set, the trip stays latched even after the die cools. It is released only when power-good, the I/O supply-valid input or the core supply-valid input drops.

The trip can only be reported while power is qualified. All three power inputs must be high, and they must have stayed high for a fixed arming delay counted in clock cycles. The delay is sized so that it ends within the 10 us window allowed after power-good rises. When any power input drops, the pin is released at once and the arming count restarts from zero. If the die is still hot when power returns, the trip is raised again as soon as the new arming delay ends.

Top module: `thermal_trip_latch`

## Requirements
- R1: Out of reset, `trip_oe` and `clk_stop_req` are 0, and the trip level equals the parameter `TRIP_RESET`.
- R2: Power is qualified when `pwr_good`, `vio_ok` and `vcore_ok` are all 1. The block is armed once power has been qualified at `ARM_CYCLES` consecutive rising clock edges. No trip is latched before that. A hot temperature is latched at the first edge after arming completes.
- R3: An armed block latches a trip when `temp_code` is greater than or equal to the trip level, compared as unsigned. A code one below the level does not trip.
- R4: A latched trip stays set while power stays qualified, whatever the temperature does.
- R5: When any of the three power inputs is 0, `trip_oe` is 0 in that same cycle. The latched trip is cleared at the next clock edge.
- R6: Losing power qualification restarts the arming count from zero. A die that is still hot trips again after a full new arming delay.
- R7: `clk_stop_req` equals the latched trip state. It is 1 whenever `trip_oe` is 1.
- R8: The pin is open-drain. Whenever `trip_oe` is 1, `trip_n_data` is 0. `trip_oe` is 0 whenever the block is not armed.
- R9: When `thr_wr_en` is 1 at a clock edge, `thr_wr_data` becomes the trip level. Comparisons from the next edge onward use the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good indication |
| vio_ok | input | 1 | I/O supply valid |
| vcore_ok | input | 1 | Core supply valid |
| temp_code | input | TEMP_W | Junction temperature in whole degrees Celsius, unsigned |
| thr_wr_en | input | 1 | Trip level write strobe |
| thr_wr_data | input | TEMP_W | New trip level |
| trip_oe | output | 1 | Output enable of the open-drain trip pin |
| trip_n_data | output | 1 | Data value of the trip pin, active low |
| clk_stop_req | output | 1 | Request to halt internal clocking |

## Verification
The bench builds the block with `ARM_CYCLES` = 16 and `TRIP_RESET` = 110. The short delay lets the bench repeat many full power-up, trip and clear sequences in a few thousand cycles. That covers re-arming after each of the three power inputs drops, and the exact edge at which arming completes. A reset trip level near the middle of the code range lets random temperatures fall on both sides of it. Written levels such as 60 test the equal and one-below boundaries away from the default.

// File: rtl/thermal_trip_latch.sv
module thermal_trip_latch #(
  parameter int TEMP_W = 8,
  parameter int ARM_CYCLES = 1000,
  parameter logic [TEMP_W-1:0] TRIP_RESET = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              vio_ok,
  input  logic              vcore_ok,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              thr_wr_en,
  input  logic [TEMP_W-1:0] thr_wr_data,
  output logic              trip_oe,
  output logic              trip_n_data,
  output logic              clk_stop_req
);
  localparam int CNT_W = $clog2(ARM_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ARM_CYCLES);

  logic [CNT_W-1:0]  arm_cnt;
  logic [TEMP_W-1:0] thr_q;
  logic              trip_q;
  logic              pwr_ok;
  logic              armed;
  logic              hot;

  assign pwr_ok = pwr_good & vio_ok & vcore_ok;
  assign armed  = pwr_ok && (arm_cnt == CNT_DONE);
  assign hot    = temp_code >= thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            arm_cnt <= '0;
    else if (!pwr_ok)      arm_cnt <= '0;
    else if (!armed)       arm_cnt <= arm_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         thr_q <= TRIP_RESET;
    else if (thr_wr_en) thr_q <= thr_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= pwr_ok & (trip_q | (armed & hot));
  end

  assign trip_oe      = trip_q & pwr_ok;
  assign trip_n_data  = ~trip_oe;
  assign clk_stop_req = trip_q;

  assert_rise_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stop_req) |-> $past(armed));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop_req && pwr_ok) |=> clk_stop_req);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !clk_stop_req);
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (arm_cnt == '0));
  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trip_oe |-> clk_stop_req);
  assert_drive_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_oe |-> !trip_n_data);
  assert_thr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_en |=> (thr_q == $past(thr_wr_data)));
endmodule

// File: tb/thermal_trip_latch_tb_top.sv
module thermal_trip_latch_tb_top;
  localparam int ARM = 16;
  localparam logic [7:0] TRIP_RST = 8'd110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_good = 0, vio_ok = 0, vcore_ok = 0, thr_wr_en = 0;
  logic [7:0] temp_code = 0, thr_wr_data = 0;
  logic trip_oe, trip_n_data, clk_stop_req;
  int total = 0, bad = 0;
  bit  rnd_phase = 0;

  int m_cnt = 0;
  bit m_trip = 0;
  logic [7:0] m_thr = TRIP_RST;

  always #5 clk = ~clk;

  thermal_trip_latch #(.TEMP_W(8), .ARM_CYCLES(ARM), .TRIP_RESET(TRIP_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .vio_ok(vio_ok), .vcore_ok(vcore_ok),
    .temp_code(temp_code), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .trip_oe(trip_oe), .trip_n_data(trip_n_data), .clk_stop_req(clk_stop_req));

  function automatic bit p_ok();
    return pwr_good & vio_ok & vcore_ok;
  endfunction

  function automatic bit exp_oe(bit trip, bit p);
    return trip & p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_trip <= 0; m_thr <= TRIP_RST;
    end else begin
      m_cnt  <= !p_ok() ? 0 : (m_cnt < ARM ? m_cnt + 1 : m_cnt);
      m_trip <= p_ok() & (m_trip | ((m_cnt == ARM) & (temp_code >= m_thr)));
      if (thr_wr_en) m_thr <= thr_wr_data;
    end
  end

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk); #2;
    if (rst_n && rnd_phase) begin
      check("R7 stop follows trip", clk_stop_req, m_trip);
      check("R5 oe gated by power", trip_oe, exp_oe(m_trip, p_ok()));
      if (trip_oe) check("R8 open-drain low", trip_n_data, 1'b0);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic power(bit v);
    pwr_good = v; vio_ok = v; vcore_ok = v;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(2);
    check("R1 reset oe", trip_oe, 1'b0);
    check("R1 reset stop", clk_stop_req, 1'b0);
    rst_n = 1; tick(1);

    // R1 default level: one below does not trip, equal trips
    temp_code = TRIP_RST - 1; power(1);
    tick(ARM + 4);
    check("R1 below reset level", trip_oe, 1'b0);
    temp_code = TRIP_RST; tick(1);
    check("R1 at reset level", trip_oe, 1'b1);
    power(0); tick(2);

    // R2 no trip before arming completes
    temp_code = 8'd250; power(1);
    tick(ARM);
    check("R2 not armed yet", trip_oe, 1'b0);
    check("R8 oe low unarmed", trip_oe, 1'b0);
    tick(1);
    check("R2 trip after arming", trip_oe, 1'b1);
    check("R7 stop on trip", clk_stop_req, 1'b1);
    check("R8 data low", trip_n_data, 1'b0);

    // R4 latch survives cooling
    temp_code = 8'd20; tick(6);
    check("R4 latched after cool", trip_oe, 1'b1);
    check("R4 stop held", clk_stop_req, 1'b1);

    // R5 / R6 for each power input
    for (int k = 0; k < 3; k++) begin
      temp_code = 8'd200;
      if (k == 0) vcore_ok = 0; else if (k == 1) pwr_good = 0; else vio_ok = 0;
      #1;
      check("R5 oe drops same cycle", trip_oe, 1'b0);
      tick(1);
      check("R5 latch cleared", clk_stop_req, 1'b0);
      power(1);
      tick(ARM);
      check("R6 no early re-trip", trip_oe, 1'b0);
      tick(1);
      check("R6 re-trip when hot", trip_oe, 1'b1);
    end

    // R9 / R3 with a written level
    power(0); thr_wr_en = 1; thr_wr_data = 8'd60; tick(1);
    thr_wr_en = 0; temp_code = 8'd59; power(1);
    tick(ARM + 5);
    check("R3 one below written level", trip_oe, 1'b0);
    temp_code = 8'd60; tick(1);
    check("R9 written level equal trips", trip_oe, 1'b1);
    check("R3 equal trips", clk_stop_req, 1'b1);
    power(0); tick(1);

    // random phase
    rnd_phase = 1;
    for (int i = 0; i < 4000; i++) begin
      pwr_good = ($urandom % 80) != 0;
      vio_ok   = ($urandom % 150) != 0;
      vcore_ok = ($urandom % 150) != 0;
      temp_code = m_thr - 8'd3 + 8'($urandom % 7);
      thr_wr_en = ($urandom % 200) == 0;
      thr_wr_data = 8'd40 + 8'($urandom % 150);
      tick(1);
    end
    rnd_phase = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule